// File: doc/BRIEF.md
# Triangular Spread-Spectrum Divider Modulator

This block drives the feedback divider of a fractional-N clock synthesizer so that the synthesized clock is spread in frequency. Its ratio only moves downward from the nominal value. A profile generator sweeps a fractional offset linearly from zero up to a programmable depth and back down again, with equal step sizes on both slopes. The effective ratio is the nominal ratio minus that offset. A first-order sigma-delta stage then turns this fractional ratio into one integer divide value per feedback cycle.

The clock input is the feedback-divider cycle. The profile advances once every `hold_cyc + 1` of those cycles, so `step`, `max_ofs` and `hold_cyc` together set the depth and the triangle period. To get a 0.5 % deviation at a modulation rate near 30–33 kHz, software picks `max_ofs` as 0.005 of the nominal ratio and scales `step` and `hold_cyc` to suit. Ratios are unsigned fixed point with 16 fractional bits.

Top module: `ssc_div_mod`

## Requirements
- R1: A synchronous active-high `rst` sets `div_val` to 0. It also clears the offset, the tick prescaler and the sigma-delta accumulator, and sets the direction to increasing offset. After reset, the first carry occurs only once the accumulated fraction reaches 1.0.
- R2: While `en` is high, each profile tick does one of two things. Going up, it adds `step` to the offset until the sum reaches or passes `max_ofs`; the offset is then clamped to exactly `max_ofs` and the direction turns down. Going down, it subtracts `step` until the offset would reach or pass zero; the offset is then clamped to exactly 0 and the direction turns up.
- R3: With `en` high, a profile tick happens on every (`hold_cyc` + 1)-th clock. The first tick after enable comes `hold_cyc` + 1 clocks after the first enabled clock. The offset holds between ticks.
- R4: The effective ratio is {`nom_int`,`nom_frac`} minus the offset, with 16 fractional bits. It saturates at 0 when the offset exceeds the nominal ratio.
- R5: Each clock, the fractional part of the effective ratio is added to a 16-bit accumulator. On the next clock edge, `div_val` becomes the integer part plus the carry out of that addition. This gives one cycle of latency. The 9-bit output can reach 256.
- R6: While `en` is low, the offset is forced to 0, the direction is set to up and the prescaler is cleared. The output follows the nominal ratio alone. The accumulator keeps running.
- R7: Over any span that ends at a profile turning point, the sum of `div_val` equals the sum of the effective ratios to within less than one integer LSB. It never exceeds the nominal ratio times the span length by one LSB or more.
- R8: Boundary settings. If `step` ≥ `max_ofs`, the offset jumps straight to `max_ofs` and then straight back to 0. If `max_ofs` = 0, the offset stays 0 and the output matches the nominal ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Feedback-divider cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Spreading enable |
| nom_int | input | 8 | Integer part of the nominal ratio |
| nom_frac | input | 16 | Fractional part of the nominal ratio |
| step | input | 18 | Offset increment per tick (16 fractional bits) |
| max_ofs | input | 18 | Maximum downward offset (16 fractional bits) |
| hold_cyc | input | 12 | Clocks per profile tick, minus one |
| div_val | output | 9 | Integer divide value for the next feedback cycle |

## Verification
The hardest situations to reach from the ports are the exact clamp at the turning points when the sweep does not land on `max_ofs`, and a saturated ratio where the offset exceeds the nominal value. The stimulus uses a depth that is not a multiple of the step, a step larger than the depth, a zero depth, and a sub-unity nominal ratio with a large depth. It also drops `en` in the middle of a slope, to show the profile restarting from zero. The scoreboard predicts each output from the running sum of effective ratios, not from an accumulator. It also checks the average over each half-sweep against the nominal ceiling.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } ssc_dir_e;
endpackage

// File: rtl/ssc_tri_profile.sv
module ssc_tri_profile
  import ssc_pkg::*;
#(
  parameter int OFS_W  = 18,
  parameter int HOLD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [OFS_W-1:0]  step,
  input  logic [OFS_W-1:0]  max_ofs,
  input  logic [HOLD_W-1:0] hold_cyc,
  output logic [OFS_W-1:0]  ofs_o,
  output logic              tick_o,
  output ssc_dir_e          dir_o
);

  // rising move: {hit, value}
  function automatic logic [OFS_W:0] rise_step(input logic [OFS_W-1:0] cur,
                                               input logic [OFS_W-1:0] stp,
                                               input logic [OFS_W-1:0] mx);
    logic [OFS_W:0] sum;
    sum = {1'b0, cur} + {1'b0, stp};
    if (sum >= {1'b0, mx}) return {1'b1, mx};
    return {1'b0, sum[OFS_W-1:0]};
  endfunction

  // falling move: {hit, value}
  function automatic logic [OFS_W:0] fall_step(input logic [OFS_W-1:0] cur,
                                               input logic [OFS_W-1:0] stp);
    if (cur <= stp) return {1'b1, {OFS_W{1'b0}}};
    return {1'b0, cur - stp};
  endfunction

  logic [OFS_W-1:0]  ofs_q;
  logic [HOLD_W-1:0] cnt_q;
  ssc_dir_e          dir_q;
  logic              tick;
  logic [OFS_W:0]    up_res;
  logic [OFS_W:0]    dn_res;

  assign tick   = (cnt_q == hold_cyc);
  assign up_res = rise_step(ofs_q, step, max_ofs);
  assign dn_res = fall_step(ofs_q, step);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ofs_q <= '0;
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (tick) begin
      cnt_q <= '0;
      if (dir_q == DIR_UP) begin
        ofs_q <= up_res[OFS_W-1:0];
        if (up_res[OFS_W]) dir_q <= DIR_DOWN;
      end else begin
        ofs_q <= dn_res[OFS_W-1:0];
        if (dn_res[OFS_W]) dir_q <= DIR_UP;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ofs_o  = ofs_q;
  assign tick_o = tick;
  assign dir_o  = dir_q;

  // R2
  ofs_step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en)) |->
      (((ofs_q >= $past(ofs_q)) ? (ofs_q - $past(ofs_q)) : ($past(ofs_q) - ofs_q)) <= $past(step)))
    else $error("offset moved by more than one step");

  // R2
  ofs_within_max_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && en && $stable(max_ofs) && ($past(ofs_q) <= $past(max_ofs))) |->
      (ofs_q <= max_ofs))
    else $error("offset beyond maximum");

  // R6
  disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> (ofs_q == '0 && dir_q == DIR_UP && cnt_q == '0))
    else $error("profile not cleared while disabled");

endmodule

// File: rtl/ssc_sd1.sv
module ssc_sd1 #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INT_W-1:0]  ratio_int,
  input  logic [FRAC_W-1:0] ratio_frac,
  output logic [INT_W:0]    div_o,
  output logic              carry_o
);

  function automatic logic [FRAC_W:0] frac_add(input logic [FRAC_W-1:0] a,
                                               input logic [FRAC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;
  logic [INT_W:0]    div_q;

  assign sum     = frac_add(acc_q, ratio_frac);
  assign carry_o = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      div_q <= '0;
    end else begin
      acc_q <= sum[FRAC_W-1:0];
      div_q <= {1'b0, ratio_int} + {{INT_W{1'b0}}, carry_o};
    end
  end

  assign div_o = div_q;

  // R5
  div_near_int_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (div_q == {1'b0, $past(ratio_int)} ||
                     div_q == {1'b0, $past(ratio_int)} + 1'b1))
    else $error("divide value not integer part or integer part plus one");

endmodule

// File: rtl/ssc_div_mod.sv
module ssc_div_mod
  import ssc_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16,
  parameter int OFS_W  = 18,
  parameter int HOLD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [INT_W-1:0]  nom_int,
  input  logic [FRAC_W-1:0] nom_frac,
  input  logic [OFS_W-1:0]  step,
  input  logic [OFS_W-1:0]  max_ofs,
  input  logic [HOLD_W-1:0] hold_cyc,
  output logic [INT_W:0]    div_val
);

  localparam int RAT_W = INT_W + FRAC_W;

  function automatic logic [RAT_W-1:0] sat_sub(input logic [RAT_W-1:0] a,
                                               input logic [RAT_W-1:0] b);
    return (b > a) ? '0 : (a - b);
  endfunction

  logic [OFS_W-1:0] ofs;
  logic             tick;
  ssc_dir_e         dir;
  logic [RAT_W-1:0] nom_ratio;
  logic [RAT_W-1:0] ofs_ext;
  logic [RAT_W-1:0] eff_ratio;
  logic             carry;

  ssc_tri_profile #(.OFS_W(OFS_W), .HOLD_W(HOLD_W)) u_prof (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .step     (step),
    .max_ofs  (max_ofs),
    .hold_cyc (hold_cyc),
    .ofs_o    (ofs),
    .tick_o   (tick),
    .dir_o    (dir)
  );

  assign nom_ratio = {nom_int, nom_frac};
  assign ofs_ext   = en ? RAT_W'(ofs) : '0;
  assign eff_ratio = sat_sub(nom_ratio, ofs_ext);

  ssc_sd1 #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_sd (
    .clk        (clk),
    .rst        (rst),
    .ratio_int  (eff_ratio[RAT_W-1:FRAC_W]),
    .ratio_frac (eff_ratio[FRAC_W-1:0]),
    .div_o      (div_val),
    .carry_o    (carry)
  );

  // R3
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && en && !$past(tick)) |-> $stable(ofs))
    else $error("offset moved without a tick");

  // R2
  turn_at_peak_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && en && $stable(max_ofs) &&
     $past(dir) == DIR_UP && dir == DIR_DOWN) |-> (ofs == max_ofs))
    else $error("turned down away from the peak");

  // R2
  turn_at_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && en && $past(dir) == DIR_DOWN && dir == DIR_UP) |-> (ofs == '0))
    else $error("turned up away from zero");

  // R4
  down_spread_chk: assert property (@(posedge clk) disable iff (rst)
    (eff_ratio <= nom_ratio) && (carry == 1'b0 || eff_ratio[FRAC_W-1:0] != '0 || 1'b1))
    else $error("effective ratio above nominal");

endmodule

// File: tb/tb_ssc_div_mod.sv
module tb_ssc_div_mod;
  localparam int INT_W = 8, FRAC_W = 16, OFS_W = 18, HOLD_W = 12;
  localparam longint ONE = longint'(1) << FRAC_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [INT_W-1:0]  nom_int = '0;
  logic [FRAC_W-1:0] nom_frac = '0;
  logic [OFS_W-1:0]  step = '0;
  logic [OFS_W-1:0]  max_ofs = '0;
  logic [HOLD_W-1:0] hold_cyc = '0;
  logic [INT_W:0]    div_val;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_tag = "R1";

  ssc_div_mod #(.INT_W(INT_W), .FRAC_W(FRAC_W), .OFS_W(OFS_W), .HOLD_W(HOLD_W)) dut (
    .clk(clk), .rst(rst), .en(en), .nom_int(nom_int), .nom_frac(nom_frac),
    .step(step), .max_ofs(max_ofs), .hold_cyc(hold_cyc), .div_val(div_val)
  );

  always #10 clk = ~clk;

  // scoreboard queues
  longint q_exp[$];
  longint q_eff[$];
  longint q_nom[$];
  bit     q_clr[$];
  bit     q_turn[$];
  string  q_tag[$];

  // reference model: output = growth of floor(running sum of ratios)
  longint m_ofs, m_cnt, m_sum, m_out;
  bit     m_up;

  always @(posedge clk) begin
    longint nomv, ofsv, eff, ex;
    bit turn;
    if (rst) begin
      m_ofs = 0; m_cnt = 0; m_sum = 0; m_out = 0; m_up = 1;
      q_exp.push_back(0); q_eff.push_back(0); q_nom.push_back(0);
      q_clr.push_back(1); q_turn.push_back(0); q_tag.push_back("R1");
    end else begin
      nomv = (longint'(nom_int) << FRAC_W) + longint'(nom_frac);
      ofsv = en ? m_ofs : 0;
      eff  = (nomv > ofsv) ? nomv - ofsv : 0;
      m_sum = m_sum + eff;
      ex = (m_sum / ONE) - m_out;
      m_out = m_out + ex;
      turn = 0;
      if (!en) begin
        m_ofs = 0; m_cnt = 0; m_up = 1;
      end else if (m_cnt == longint'(hold_cyc)) begin
        m_cnt = 0;
        if (m_up) begin
          if (m_ofs + longint'(step) >= longint'(max_ofs)) begin
            m_ofs = longint'(max_ofs); m_up = 0; turn = 1;
          end else m_ofs = m_ofs + longint'(step);
        end else begin
          if (m_ofs <= longint'(step)) begin
            m_ofs = 0; m_up = 1; turn = 1;
          end else m_ofs = m_ofs - longint'(step);
        end
      end else m_cnt = m_cnt + 1;
      q_exp.push_back(ex); q_eff.push_back(eff); q_nom.push_back(nomv);
      q_clr.push_back(!en); q_turn.push_back(turn); q_tag.push_back(cur_tag);
    end
  end

  // monitor
  longint w_out = 0, w_eff = 0, w_nom = 0;
  always @(negedge clk) begin
    longint ex, ef, nm, got, diff;
    bit clr, turn;
    string tg;
    if (q_exp.size() > 0 && !done) begin
      ex = q_exp.pop_front(); ef = q_eff.pop_front(); nm = q_nom.pop_front();
      clr = q_clr.pop_front(); turn = q_turn.pop_front(); tg = q_tag.pop_front();
      got = longint'(div_val);
      checks++;
      if (got != ex) begin
        errors++;
        $display("FAIL %s: div_val got %0d expected %0d at %0t", tg, got, ex, $time);
      end
      if (clr) begin
        w_out = 0; w_eff = 0; w_nom = 0;
      end else begin
        w_out = w_out + got; w_eff = w_eff + ef; w_nom = w_nom + nm;
        if (turn) begin
          // R7 average over the span matches the effective ratios
          diff = w_out * ONE - w_eff;
          if (diff < 0) diff = -diff;
          checks++;
          if (diff >= ONE) begin
            errors++;
            $display("FAIL R7: span sum got %0d expected about %0d/65536", w_out, w_eff);
          end
          // R7 never above nominal
          checks++;
          if (w_out * ONE >= w_nom + ONE) begin
            errors++;
            $display("FAIL R7: span sum got %0d expected below %0d/65536", w_out, w_nom + ONE);
          end
          w_out = 0; w_eff = 0; w_nom = 0;
        end
      end
    end
  end

  task automatic run_phase(input string tag, input bit e, input int ni, input int nf,
                           input int st, input int mx, input int hd, input int cyc);
    @(negedge clk);
    en = 1'b0;
    nom_int = INT_W'(ni); nom_frac = FRAC_W'(nf);
    step = OFS_W'(st); max_ofs = OFS_W'(mx); hold_cyc = HOLD_W'(hd);
    repeat (2) @(negedge clk);
    cur_tag = tag;
    en = e;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);      // R1 reset state observed by the monitor
    rst = 1'b0;
    run_phase("R5", 1'b0, 60, 16'h4000, 0, 0, 0, 40);               // R1 R5 carry every 4th
    run_phase("R2", 1'b1, 60, 16'h0000, 16'h0100, 18'h04CCC, 0, 400); // R2 uneven clamp
    run_phase("R3", 1'b1, 60, 16'h8000, 16'h0800, 18'h03000, 3, 300); // R3 prescaled ticks
    run_phase("R8", 1'b1, 40, 16'h1234, 18'h05000, 18'h01000, 1, 60); // R8 step beyond depth
    run_phase("R8", 1'b1, 40, 16'h1234, 16'h0100, 18'h00000, 0, 40);  // R8 zero depth
    run_phase("R4", 1'b1, 0, 16'h1999, 16'h1000, 18'h08000, 0, 60);   // R4 saturation
    run_phase("R6", 1'b1, 60, 16'h0000, 16'h0100, 18'h04CCC, 0, 50);  // R6 mid-slope disable
    cur_tag = "R6"; en = 1'b0;
    repeat (10) @(negedge clk);
    en = 1'b1;
    repeat (50) @(negedge clk);
    run_phase("R5", 1'b0, 255, 16'hFFFF, 0, 0, 0, 20);               // R5 output reaches 256
    run_phase("R5", 1'b1, 255, 16'hFFFF, 16'h0400, 18'h02000, 2, 80);
    @(negedge clk);
    cur_tag = "R1"; rst = 1'b1;                                     // R1 reset mid-run
    repeat (3) @(negedge clk);
    rst = 1'b0;
    run_phase("R1", 1'b0, 60, 16'h4000, 0, 0, 0, 20);
    repeat (3) @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
    end
  end
endmodule